// File: doc/BRIEF.md
# A/D Acquisition Controller

This block is the register-mapped sequencer that sits between an 8-bit host bus and an external analog-to-digital converter. The host programs a channel number, an amplifier gain code and a mode byte. The mode byte picks what starts a conversion: a software strobe, a periodic pacer tick or a rising edge on an external pin. It also picks how the finished result is handed off: polling, a latched interrupt or a pair of DMA requests. The controller issues a one-cycle start pulse to the converter. When the converter signals completion, it captures the 12-bit result and exposes it as two readable bytes, with an active-low ready flag in the upper byte.

The multiplexer, the programmable amplifier and the converter are external. The block only drives their select lines and the start pulse, and it samples the done strobe and the result bus.

Top module: `adc_acq_ctrl`

## Requirements
- R1: A read returns its data on `bus_rdata` one cycle after the address is presented. Offset 0x4 returns result bits 7..0. Offset 0x5 returns result bits 11..8 in bits 3..0, the ready flag in bit 4 and zeros in bits 7..5.
- R2: The ready flag is 1 after reset and from the start of a conversion until its done strobe. It becomes 0 in the cycle after the result is captured.
- R3: In software mode, any write to offset 0xC yields exactly one single-cycle `conv_start` pulse, whatever the data written.
- R4: When the external source is selected, the `ext_trig` pin passes through a two-flop synchronizer, and only a rising edge starts a conversion. A pin held high gives a single start.
- R5: The mode register is at offset 0xB. Bits 2..0 encode: 001 = software trigger with polling, 010 = pacer with DMA, 110 = pacer with interrupt, 100 = pacer with polling. Any other code disables all triggers. For codes 010, 110 and 100, bit 3 = 1 substitutes the external pin for the pacer. Reset value 0 (disabled).
- R6: Trigger sources not selected by the mode register have no effect.
- R7: A trigger that arrives while a conversion is in progress is dropped.
- R8: In interrupt mode each completion sets `irq`. `irq` stays high until a write to offset 0x8 clears it. Completions that occur while it is already set do not re-raise it after the clear.
- R9: In DMA mode each completion produces two requests on `dma_req`. Each request is held until `dma_ack` is seen. `dma_req` is low for exactly one cycle between the two requests, and the second request is raised only after the first is acknowledged.
- R10: A write to offset 0xA sets `mux_sel` from data bits 3..0. While `diff_mode` is 1, `mux_sel[3]` is forced to 0.
- R11: A write to offset 0x9 sets `gain_sel` from data bits 2..0, where codes 0..4 mean gain 1, 2, 4, 8, 16. A code of 5..7 is ignored and the previous code is kept.
- R12: In polling modes neither `irq` nor `dma_req` is ever raised.
- R13: After reset, `conv_start`, `irq`, `dma_req`, `mux_sel` and `gain_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| pacer_tick | input | 1 | Single-cycle periodic trigger |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| diff_mode | input | 1 | Differential input wiring; masks channel bit 3 |
| mux_sel | output | 4 | Analog multiplexer channel select |
| gain_sel | output | 3 | Amplifier gain code |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 12 | Converter result, valid with `conv_done` |
| irq | output | 1 | Latched interrupt request |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge |

## Verification
The bench sends a second software strobe while a slow conversion is still running. A controller that failed to gate triggers on the busy state would restart the converter and emit a second start pulse. It fires a pacer tick, a software write and an external edge under modes that do not select them; wrong mode decoding would show up as extra starts. It lets two interrupt-mode conversions complete before one clear, which catches a latch that re-arms from a stale completion. It also stalls the DMA acknowledge for several cycles, which exposes a request that drops early or a second request that overlaps the first.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

  localparam int OFS_W = 4;

  localparam logic [OFS_W-1:0] OFS_RES_LO  = 4'h4;
  localparam logic [OFS_W-1:0] OFS_RES_HI  = 4'h5;
  localparam logic [OFS_W-1:0] OFS_IRQ_CLR = 4'h8;
  localparam logic [OFS_W-1:0] OFS_GAIN    = 4'h9;
  localparam logic [OFS_W-1:0] OFS_CHAN    = 4'hA;
  localparam logic [OFS_W-1:0] OFS_MODE    = 4'hB;
  localparam logic [OFS_W-1:0] OFS_SWTRIG  = 4'hC;

  localparam int MODE_W = 4;

  typedef enum logic [1:0] {
    TRG_NONE  = 2'd0,
    TRG_SOFT  = 2'd1,
    TRG_PACER = 2'd2,
    TRG_EXT   = 2'd3
  } trig_src_e;

  typedef enum logic [1:0] {
    XFR_POLL = 2'd0,
    XFR_IRQ  = 2'd1,
    XFR_DMA  = 2'd2
  } xfer_e;

  typedef enum logic [1:0] {
    DMA_IDLE   = 2'd0,
    DMA_REQ_LO = 2'd1,
    DMA_GAP    = 2'd2,
    DMA_REQ_HI = 2'd3
  } dma_st_e;

  typedef struct packed {
    trig_src_e src;
    xfer_e     xfer;
  } mode_cfg_t;

  // Map the stored mode nibble to a trigger source and a hand-off method.
  function automatic mode_cfg_t decode_mode(input logic [MODE_W-1:0] m);
    mode_cfg_t c;
    trig_src_e timed;
    timed  = m[3] ? TRG_EXT : TRG_PACER;
    c.src  = TRG_NONE;
    c.xfer = XFR_POLL;
    case (m[2:0])
      3'b001: c.src = TRG_SOFT;
      3'b010: begin c.src = timed; c.xfer = XFR_DMA; end
      3'b110: begin c.src = timed; c.xfer = XFR_IRQ; end
      3'b100: c.src = timed;
      default: c.src = TRG_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/adc_acq_regs.sv
module adc_acq_regs
  import adc_acq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RES_W    = 12,
  parameter int CH_W     = 4,
  parameter int GAIN_W   = 3,
  parameter int GAIN_MAX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              diff_mode,
  input  logic [RES_W-1:0]  result,
  input  logic              ready_n,
  output logic [CH_W-1:0]   mux_sel,
  output logic [GAIN_W-1:0] gain_sel,
  output mode_cfg_t         mode_cfg,
  output logic              sw_strobe,
  output logic              clr_strobe
);

  localparam int HI_W = RES_W - DATA_W;

  logic [CH_W-1:0]   chan_q;
  logic [CH_W-1:0]   chan_nxt;
  logic [MODE_W-1:0] mode_q;
  logic              wr_chan;
  logic              wr_gain;
  logic              wr_mode;
  logic              gain_ok;
  logic [DATA_W-1:0] hi_byte;
  logic [DATA_W-1:0] rd_nxt;
  logic              unused_wdata;

  assign wr_chan    = bus_wr && (bus_addr == OFS_CHAN);
  assign wr_gain    = bus_wr && (bus_addr == OFS_GAIN);
  assign wr_mode    = bus_wr && (bus_addr == OFS_MODE);
  assign sw_strobe  = bus_wr && (bus_addr == OFS_SWTRIG);
  assign clr_strobe = bus_wr && (bus_addr == OFS_IRQ_CLR);

  assign gain_ok  = bus_wdata[GAIN_W-1:0] <= GAIN_W'(GAIN_MAX);
  assign chan_nxt = wr_chan ? bus_wdata[CH_W-1:0] : chan_q;
  assign mode_cfg = decode_mode(mode_q);

  assign unused_wdata = &{1'b0, bus_wdata[DATA_W-1:CH_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q   <= '0;
      mux_sel  <= '0;
      gain_sel <= '0;
      mode_q   <= '0;
    end else begin
      chan_q <= chan_nxt;
      // The channel output is recomputed every cycle so the strap takes effect at once.
      if (diff_mode) mux_sel <= {1'b0, chan_nxt[CH_W-2:0]};
      else           mux_sel <= chan_nxt;
      if (wr_gain && gain_ok) gain_sel <= bus_wdata[GAIN_W-1:0];
      if (wr_mode) mode_q <= bus_wdata[MODE_W-1:0];
    end
  end

  always_comb begin
    hi_byte             = '0;
    hi_byte[HI_W-1:0]   = result[RES_W-1:DATA_W];
    hi_byte[HI_W]       = ready_n;
    case (bus_addr)
      OFS_RES_LO: rd_nxt = result[DATA_W-1:0];
      OFS_RES_HI: rd_nxt = hi_byte;
      default:    rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end

endmodule

// File: rtl/adc_acq_trig.sv
module adc_acq_trig
  import adc_acq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  trig_src_e src,
  input  logic      sw_strobe,
  input  logic      pacer_tick,
  input  logic      ext_trig,
  input  logic      busy,
  output logic      fire
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] ext_q;
  logic               ext_rise;
  logic               want;

  // Synchronizer stages plus one history flop for edge detection.
  always_ff @(posedge clk) begin
    if (rst) ext_q <= '0;
    else     ext_q <= {ext_q[CHAIN_W-2:0], ext_trig};
  end

  assign ext_rise = ext_q[SYNC_STAGES-1] & ~ext_q[SYNC_STAGES];

  always_comb begin
    case (src)
      TRG_SOFT:  want = sw_strobe;
      TRG_PACER: want = pacer_tick;
      TRG_EXT:   want = ext_rise;
      default:   want = 1'b0;
    endcase
  end

  assign fire = want & ~busy;

endmodule

// File: rtl/adc_acq_core.sv
module adc_acq_core
  import adc_acq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  xfer_e            xfer,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             clr_strobe,
  input  logic             dma_ack,
  output logic             conv_start,
  output logic             busy,
  output logic             ready_n,
  output logic [RES_W-1:0] result,
  output logic             irq,
  output logic             dma_req
);

  dma_st_e dma_st;
  logic    done_evt;

  assign done_evt = conv_done & busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start <= 1'b0;
      busy       <= 1'b0;
      ready_n    <= 1'b1;
      result     <= '0;
    end else begin
      conv_start <= fire;
      if (fire) begin
        busy    <= 1'b1;
        ready_n <= 1'b1;
      end else if (done_evt) begin
        busy    <= 1'b0;
        ready_n <= 1'b0;
        result  <= conv_data;
      end
    end
  end

  // A completion wins over a clear written in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)                                irq <= 1'b0;
    else if (done_evt && xfer == XFR_IRQ)   irq <= 1'b1;
    else if (clr_strobe)                    irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_st <= DMA_IDLE;
    end else begin
      case (dma_st)
        DMA_IDLE:   if (done_evt && xfer == XFR_DMA) dma_st <= DMA_REQ_LO;
        DMA_REQ_LO: if (dma_ack) dma_st <= DMA_GAP;
        DMA_GAP:    dma_st <= DMA_REQ_HI;
        DMA_REQ_HI: if (dma_ack) dma_st <= DMA_IDLE;
        default:    dma_st <= DMA_IDLE;
      endcase
    end
  end

  assign dma_req = (dma_st == DMA_REQ_LO) || (dma_st == DMA_REQ_HI);

endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
  import adc_acq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RES_W       = 12,
  parameter int CH_W        = 4,
  parameter int GAIN_W      = 3,
  parameter int GAIN_MAX    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pacer_tick,
  input  logic              ext_trig,
  input  logic              diff_mode,
  output logic [CH_W-1:0]   mux_sel,
  output logic [GAIN_W-1:0] gain_sel,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              irq,
  output logic              dma_req,
  input  logic              dma_ack
);

  mode_cfg_t        mode_cfg;
  logic             sw_strobe;
  logic             clr_strobe;
  logic             fire;
  logic             busy;
  logic             ready_n;
  logic [RES_W-1:0] result;

  adc_acq_regs #(
    .DATA_W   (DATA_W),
    .RES_W    (RES_W),
    .CH_W     (CH_W),
    .GAIN_W   (GAIN_W),
    .GAIN_MAX (GAIN_MAX)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .diff_mode  (diff_mode),
    .result     (result),
    .ready_n    (ready_n),
    .mux_sel    (mux_sel),
    .gain_sel   (gain_sel),
    .mode_cfg   (mode_cfg),
    .sw_strobe  (sw_strobe),
    .clr_strobe (clr_strobe)
  );

  adc_acq_trig #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_trig (
    .clk        (clk),
    .rst        (rst),
    .src        (mode_cfg.src),
    .sw_strobe  (sw_strobe),
    .pacer_tick (pacer_tick),
    .ext_trig   (ext_trig),
    .busy       (busy),
    .fire       (fire)
  );

  adc_acq_core #(
    .RES_W (RES_W)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .xfer       (mode_cfg.xfer),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .clr_strobe (clr_strobe),
    .dma_ack    (dma_ack),
    .conv_start (conv_start),
    .busy       (busy),
    .ready_n    (ready_n),
    .result     (result),
    .irq        (irq),
    .dma_req    (dma_req)
  );

endmodule

// File: rtl/adc_acq_chk.sv
module adc_acq_chk
  import adc_acq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [OFS_W-1:0] bus_addr,
  input logic             bus_wr,
  input logic             diff_mode,
  input logic [CH_W-1:0]  mux_sel,
  input logic             conv_start,
  input logic             conv_done,
  input logic             ready_n,
  input logic             irq,
  input logic             dma_req,
  input logic             dma_ack
);

  logic pend;

  // Independent view of an outstanding conversion, built from the port pulses.
  always_ff @(posedge clk) begin
    if (rst)             pend <= 1'b0;
    else if (conv_start) pend <= 1'b1;
    else if (conv_done)  pend <= 1'b0;
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);                                      // R3

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    pend |-> !conv_start);                                            // R7

  AST_READY_ON_START: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ready_n);                                          // R2

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (pend && conv_done) |=> !ready_n);                                // R2

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !(bus_wr && bus_addr == OFS_IRQ_CLR)) |=> irq);           // R8

  AST_DMA_HELD: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_ack) |=> dma_req);                               // R9

  AST_DIFF_MSB: assert property (@(posedge clk) disable iff (rst)
    $past(diff_mode) |-> !mux_sel[CH_W-1]);                           // R10

endmodule

bind adc_acq_ctrl adc_acq_chk #(.CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .diff_mode  (diff_mode),
  .mux_sel    (mux_sel),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .ready_n    (ready_n),
  .irq        (irq),
  .dma_req    (dma_req),
  .dma_ack    (dma_ack)
);

// File: tb/adc_acq_ctrl_bench.sv
module adc_acq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr;
  logic [7:0]  bus_rdata;
  logic        pacer_tick;
  logic        ext_trig;
  logic        diff_mode;
  logic [3:0]  mux_sel;
  logic [2:0]  gain_sel;
  logic        conv_start;
  logic        conv_done;
  logic [11:0] conv_data;
  logic        irq;
  logic        dma_req;
  logic        dma_ack;

  int n_checks = 0;
  int n_fail   = 0;
  int starts   = 0;
  int dma_rises = 0;
  int irq_hi_cycles = 0;
  int conv_lat = 4;
  logic [11:0] next_sample = 12'h000;
  logic dma_prev = 1'b0;

  always #2 clk = ~clk;

  adc_acq_ctrl u_adc_acq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pacer_tick(pacer_tick),
    .ext_trig(ext_trig), .diff_mode(diff_mode), .mux_sel(mux_sel),
    .gain_sel(gain_sel), .conv_start(conv_start), .conv_done(conv_done),
    .conv_data(conv_data), .irq(irq), .dma_req(dma_req), .dma_ack(dma_ack)
  );

  always @(posedge clk) begin
    if (conv_start) starts <= starts + 1;
    if (dma_req && !dma_prev) dma_rises <= dma_rises + 1;
    if (irq) irq_hi_cycles <= irq_hi_cycles + 1;
    dma_prev <= dma_req;
  end

  // Converter model: completes conv_lat cycles after a start pulse.
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        repeat (conv_lat) @(negedge clk);
        conv_data = next_sample;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pacer();
    @(negedge clk);
    pacer_tick = 1'b1;
    @(negedge clk);
    pacer_tick = 1'b0;
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] v;
    bit ok = 0;
    for (int i = 0; i < 100; i++) begin
      bus_read(4'h5, v);
      if (!v[4]) begin ok = 1; break; end
    end
    check(tag, int'(ok), 1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R13 conv_start", conv_start, 0);
    check("R13 irq", irq, 0);
    check("R13 dma_req", dma_req, 0);
    check("R13 mux_sel", mux_sel, 0);
    check("R13 gain_sel", gain_sel, 0);
    bus_read(4'h5, v);
    check("R2 ready flag after reset", v, 8'h10);
  endtask

  task automatic t_soft_poll();
    logic [7:0] v;
    int s0;
    conv_lat = 10;
    next_sample = 12'hA5C;
    bus_write(4'hB, 8'h01);
    s0 = starts;
    bus_write(4'hC, 8'h00);
    bus_read(4'h5, v);
    check("R2 ready flag while pending", v[4], 1);
    wait_ready("R2 ready clears after done");
    bus_read(4'h4, v);
    check("R1 low byte", v, 8'h5C);
    bus_read(4'h5, v);
    check("R1 high byte and flag", v, 8'h0A);
    check("R3 one start per strobe", starts - s0, 1);
    conv_lat = 4;
  endtask

  task automatic t_ignore();
    int s0;
    bus_write(4'hB, 8'h01);
    s0 = starts;
    pulse_pacer();
    @(negedge clk) ext_trig = 1'b1;
    idle(8);
    check("R6 pacer and pin ignored in software mode", starts - s0, 0);
    ext_trig = 1'b0;
    idle(4);
    bus_write(4'hB, 8'h00);
    s0 = starts;
    bus_write(4'hC, 8'hFF);
    pulse_pacer();
    idle(6);
    check("R5 disabled mode starts nothing", starts - s0, 0);
  endtask

  task automatic t_busy();
    int s0;
    conv_lat = 20;
    bus_write(4'hB, 8'h01);
    s0 = starts;
    bus_write(4'hC, 8'h12);
    bus_write(4'hC, 8'h34);
    idle(3);
    bus_write(4'hC, 8'h56);
    wait_ready("R7 busy conversion completes");
    idle(4);
    check("R7 triggers during conversion dropped", starts - s0, 1);
    conv_lat = 4;
  endtask

  task automatic t_irq();
    int s0;
    next_sample = 12'h3C1;
    bus_write(4'hB, 8'h06);
    s0 = starts;
    bus_write(4'hC, 8'h00);
    idle(6);
    check("R6 software strobe ignored in pacer mode", starts - s0, 0);
    check("R8 irq low before conversion", irq, 0);
    pulse_pacer();
    wait_ready("R8 first conversion");
    check("R8 irq set after completion", irq, 1);
    pulse_pacer();
    wait_ready("R8 second conversion");
    check("R8 irq still set", irq, 1);
    bus_write(4'h8, 8'h5A);
    idle(3);
    check("R8 irq cleared and not re-raised", irq, 0);
    pulse_pacer();
    wait_ready("R8 third conversion");
    check("R8 irq raised again after clear", irq, 1);
    bus_write(4'h8, 8'h00);
    idle(2);
    check("R8 irq cleared", irq, 0);
  endtask

  task automatic t_ext();
    int s0;
    bus_write(4'hB, 8'h0C);
    s0 = starts;
    pulse_pacer();
    idle(6);
    check("R6 pacer ignored in external mode", starts - s0, 0);
    @(negedge clk) ext_trig = 1'b1;
    idle(20);
    check("R4 held pin starts once", starts - s0, 1);
    ext_trig = 1'b0;
    idle(5);
    ext_trig = 1'b1;
    idle(12);
    ext_trig = 1'b0;
    idle(4);
    check("R4 second rising edge starts again", starts - s0, 2);
  endtask

  task automatic t_dma();
    int r0;
    bit seen = 0;
    logic [7:0] v;
    next_sample = 12'h7E4;
    bus_write(4'hB, 8'h02);
    r0 = dma_rises;
    pulse_pacer();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (dma_req) begin seen = 1; break; end
    end
    check("R9 first request raised", int'(seen), 1);
    idle(5);
    check("R9 request held without ack", dma_req, 1);
    dma_ack = 1'b1;
    @(negedge clk) dma_ack = 1'b0;
    check("R9 one idle cycle after first ack", dma_req, 0);
    @(negedge clk);
    check("R9 second request raised", dma_req, 1);
    idle(3);
    check("R9 second request held", dma_req, 1);
    dma_ack = 1'b1;
    @(negedge clk) dma_ack = 1'b0;
    idle(5);
    check("R9 no third request", dma_req, 0);
    check("R9 exactly two requests", dma_rises - r0, 2);
    bus_read(4'h4, v);
    check("R1 low byte in DMA mode", v, 8'hE4);
  endtask

  task automatic t_poll_quiet();
    int r0, q0;
    bus_write(4'hB, 8'h04);
    r0 = dma_rises;
    q0 = irq_hi_cycles;
    pulse_pacer();
    wait_ready("R12 pacer poll conversion");
    bus_write(4'hB, 8'h01);
    bus_write(4'hC, 8'h00);
    wait_ready("R12 software poll conversion");
    idle(4);
    check("R12 no DMA in polling", dma_rises - r0, 0);
    check("R12 no irq in polling", irq_hi_cycles - q0, 0);
  endtask

  task automatic t_chan_gain();
    diff_mode = 1'b0;
    bus_write(4'hA, 8'hFB);
    check("R10 channel single-ended", mux_sel, 4'hB);
    @(negedge clk) diff_mode = 1'b1;
    @(negedge clk);
    check("R10 channel differential masks bit 3", mux_sel, 4'h3);
    bus_write(4'hA, 8'h0E);
    check("R10 differential write", mux_sel, 4'h6);
    @(negedge clk) diff_mode = 1'b0;
    @(negedge clk);
    check("R10 bit 3 restored", mux_sel, 4'hE);
    bus_write(4'h9, 8'h03);
    check("R11 gain code 3", gain_sel, 3);
    bus_write(4'h9, 8'h06);
    check("R11 invalid code ignored", gain_sel, 3);
    bus_write(4'h9, 8'h04);
    check("R11 gain code 4", gain_sel, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0;
    pacer_tick = 1'b0; ext_trig = 1'b0; diff_mode = 1'b0; dma_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_soft_poll();
    t_ignore();
    t_busy();
    t_irq();
    t_ext();
    t_dma();
    t_poll_quiet();
    t_chan_gain();
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule